// File: doc/BRIEF.md
# Charge voltage limit clamp

This block turns a requested charge voltage, given in millivolts, into the setpoint code that drives the charger's voltage output stage. The output stage adds a fixed internal reference of 1104 mV to whatever it is given, so the block removes that amount first. It then expresses the remainder as a count of 16 mV steps, rounding down. A request below the reference produces a setpoint of zero.

A hardware limit caps the setpoint, and software has no means to override it. A resistor on a limit-select pin is sensed by four comparators. Their outputs reach the block as a 4-bit thermometer code, which picks one of five ceilings: 4240, 4304, 4432, 4512 or 5504 mV. When a request is above the selected ceiling, the block outputs the ceiling's code instead and raises an over-range flag.

The request is latched by a write strobe. The clamp is re-evaluated on every clock, so a change in the limit pin takes effect at the next edge even when no new write arrives.

Top module: `chg_vlim_clamp`

## Requirements
- R1: While reset is asserted, and after it is released until the first clock edge, `vset_code`, `vset_over` and `lim_idx` read 0.
- R2: `lim_idx` equals the number of contiguous ones in `lim_therm`, counted upward from bit 0. So 0000→0, 0001→1, 0011→2, 0111→3 and 1111→4, and a non-monotonic code such as 0101 gives 1 and 0010 gives 0. Indices 0 to 4 select ceilings of 4240, 4304, 4432, 4512 and 5504 mV.
- R3: For a held request r with 1104 ≤ r ≤ ceiling, `vset_code` = floor((r − 1104) / 16). For example, 1119 gives 0 and 1120 gives 1.
- R4: For a held request below 1104 mV, `vset_code` is 0 and `vset_over` is 0.
- R5: For a held request above the selected ceiling, `vset_code` equals the ceiling code: 196, 200, 208, 213 or 275 for indices 0 to 4. `vset_over` is 1 in this case. A request exactly equal to the ceiling is not over range.
- R6: A request is taken only at a clock edge where `req_wr` is 1, and the outputs reflect it after that same edge. A change on `req_mv` while `req_wr` is 0 has no effect.
- R7: When `lim_therm` changes while a request is held, `lim_idx`, `vset_code` and `vset_over` follow the new level after the next clock edge. This includes clearing `vset_over` when the new ceiling is at or above the held request.
- R8: A write of an in-range request clears a previously set `vset_over`.
- R9: `vset_code` never exceeds the ceiling code of the level reported on `lim_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_mv | input | 16 | Requested charge voltage in mV |
| req_wr | input | 1 | Write strobe; latches `req_mv` |
| lim_therm | input | 4 | Thermometer code from the limit-select comparators |
| vset_code | output | 9 | Setpoint in 16 mV steps above the reference |
| vset_over | output | 1 | Set while the held request exceeds the ceiling |
| lim_idx | output | 3 | Decoded limit level, 0 to 4 |

## Verification
The bench targets the step edges around the reference: 1103, 1104, 1119 and 1120 mV. A design that subtracted before comparing would wrap to a huge code at these points, and a design that rounded up would be one step high. Each ceiling is tested at exactly its value and at one millivolt above it, which exposes an off-by-one compare that either flags an exact-limit request or lets a request slip past the clamp. Non-monotonic thermometer codes are applied, and would be mis-decoded by a plain population count. A limit change made with no new write exposes a design that clamps only at write time and leaves a stale setpoint or flag.

// File: rtl/vlim_pkg.sv
package vlim_pkg;

   localparam int unsigned NUM_LVL = 5;
   localparam int unsigned THERM_W = NUM_LVL - 1;
   localparam int unsigned LVL_W   = $clog2(NUM_LVL);

   typedef logic [LVL_W-1:0] lvl_t;

   // Ceiling in mV for each decoded level; out-of-range indices map to the top level.
   function automatic int unsigned lvl_max_mv(input int unsigned idx);
      case (idx)
         0:       return 4240;
         1:       return 4304;
         2:       return 4432;
         3:       return 4512;
         default: return 5504;
      endcase
   endfunction

   // Setpoint code of a level's ceiling, given the reference and step size.
   function automatic int unsigned lvl_code(input int unsigned idx,
                                            input int unsigned ref_mv,
                                            input int unsigned step_log2);
      return (lvl_max_mv(idx) - ref_mv) >> step_log2;
   endfunction

endpackage

// File: rtl/vlim_therm_dec.sv
module vlim_therm_dec #(
   parameter int unsigned THERM_W = vlim_pkg::THERM_W,
   parameter int unsigned LVL_W   = vlim_pkg::LVL_W
) (
   input  logic [THERM_W-1:0] therm,
   output logic [LVL_W-1:0]   lvl
);

   generate
      if (THERM_W < 1) begin : g_bad_w
         $error("vlim_therm_dec: THERM_W must be at least 1");
      end
      if ((1 << LVL_W) <= THERM_W) begin : g_bad_lvl
         $error("vlim_therm_dec: LVL_W too narrow for THERM_W");
      end
   endgenerate

   // run[i] is set only when bits 0..i are all set.
   logic [THERM_W-1:0] run;

   generate
      for (genvar i = 0; i < THERM_W; i++) begin : g_run
         if (i == 0) begin : g_first
            assign run[i] = therm[i];
         end else begin : g_next
            assign run[i] = run[i-1] & therm[i];
         end
      end
   endgenerate

   always_comb begin
      lvl = '0;
      for (int i = 0; i < THERM_W; i++) begin
         if (run[i]) lvl = LVL_W'(i + 1);
      end
   end

endmodule

// File: rtl/vlim_clamp_path.sv
module vlim_clamp_path #(
   parameter int unsigned REQ_W     = 16,
   parameter int unsigned SP_W      = 9,
   parameter int unsigned REF_MV    = 1104,
   parameter int unsigned STEP_LOG2 = 4,
   parameter int unsigned LVL_W     = vlim_pkg::LVL_W
) (
   input  logic [REQ_W-1:0] req,
   input  logic [LVL_W-1:0] lvl,
   output logic [SP_W-1:0]  code,
   output logic             over
);

   localparam int unsigned CW = REQ_W + 1;

   logic [CW-1:0] req_x, lim_x, ref_x, sel_x, delta_x, steps_x;
   logic          under;

   always_comb begin
      req_x = CW'(req);
      ref_x = CW'(REF_MV);
      lim_x = CW'(vlim_pkg::lvl_max_mv(32'(lvl)));
      under = req_x < ref_x;
      over  = req_x > lim_x;
      sel_x = over ? lim_x : req_x;
      delta_x = sel_x - ref_x;
   end

   generate
      if (STEP_LOG2 == 0) begin : g_unit_step
         assign steps_x = delta_x;
      end else begin : g_shift_step
         assign steps_x = delta_x >> STEP_LOG2;
      end
   endgenerate

   assign code = under ? '0 : SP_W'(steps_x);

endmodule

// File: rtl/chg_vlim_clamp.sv
module chg_vlim_clamp #(
   parameter int unsigned REQ_W     = 16,
   parameter int unsigned SP_W      = 9,
   parameter int unsigned REF_MV    = 1104,
   parameter int unsigned STEP_LOG2 = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [REQ_W-1:0]              req_mv,
   input  logic                          req_wr,
   input  logic [vlim_pkg::THERM_W-1:0]  lim_therm,
   output logic [SP_W-1:0]               vset_code,
   output logic                          vset_over,
   output logic [vlim_pkg::LVL_W-1:0]    lim_idx
);

   import vlim_pkg::*;

   localparam int unsigned TOP_CODE = lvl_code(NUM_LVL - 1, REF_MV, STEP_LOG2);

   generate
      if (REF_MV >= lvl_max_mv(0)) begin : g_bad_ref
         $error("chg_vlim_clamp: REF_MV must lie below every ceiling");
      end
      if (TOP_CODE >= (1 << SP_W)) begin : g_bad_sp
         $error("chg_vlim_clamp: SP_W too narrow for the top ceiling code");
      end
      if ((1 << REQ_W) <= lvl_max_mv(NUM_LVL - 1)) begin : g_bad_req
         $error("chg_vlim_clamp: REQ_W cannot express the top ceiling");
      end
   endgenerate

   logic [REQ_W-1:0] req_q, req_eff;
   lvl_t             lvl_d;
   logic [SP_W-1:0]  code_d;
   logic             over_d;

   assign req_eff = req_wr ? req_mv : req_q;

   vlim_therm_dec #(
      .THERM_W (THERM_W),
      .LVL_W   (LVL_W)
   ) dec_i (
      .therm (lim_therm),
      .lvl   (lvl_d)
   );

   vlim_clamp_path #(
      .REQ_W     (REQ_W),
      .SP_W      (SP_W),
      .REF_MV    (REF_MV),
      .STEP_LOG2 (STEP_LOG2),
      .LVL_W     (LVL_W)
   ) path_i (
      .req  (req_eff),
      .lvl  (lvl_d),
      .code (code_d),
      .over (over_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q     <= '0;
         vset_code <= '0;
         vset_over <= 1'b0;
         lim_idx   <= '0;
      end else begin
         req_q     <= req_eff;
         vset_code <= code_d;
         vset_over <= over_d;
         lim_idx   <= lvl_d;
      end
   end

endmodule

// File: rtl/vlim_clamp_chk.sv
module vlim_clamp_chk #(
   parameter int unsigned REQ_W     = 16,
   parameter int unsigned SP_W      = 9,
   parameter int unsigned REF_MV    = 1104,
   parameter int unsigned STEP_LOG2 = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic [REQ_W-1:0]              req_mv,
   input logic                          req_wr,
   input logic [vlim_pkg::THERM_W-1:0]  lim_therm,
   input logic [SP_W-1:0]               vset_code,
   input logic                          vset_over,
   input logic [vlim_pkg::LVL_W-1:0]    lim_idx
);

   logic [1:0] up_cnt;
   logic       armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           up_cnt <= '0;
      else if (up_cnt != 2) up_cnt <= up_cnt + 2'd1;
   end
   assign armed = (up_cnt == 2);

   // R9
   code_within_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(vset_code) <= vlim_pkg::lvl_code(32'(lim_idx), REF_MV, STEP_LOG2));

   // R5
   over_pins_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vset_over |-> 32'(vset_code) == vlim_pkg::lvl_code(32'(lim_idx), REF_MV, STEP_LOG2));

   // R4
   below_ref_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_wr && 32'(req_mv) < REF_MV) |=> (vset_code == '0 && !vset_over));

   // R2
   lvl_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(lim_idx) < vlim_pkg::NUM_LVL);

   // R6
   idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !req_wr && $stable(lim_therm)) |=> ($stable(vset_code) && $stable(vset_over)));

endmodule

bind chg_vlim_clamp vlim_clamp_chk #(
   .REQ_W     (REQ_W),
   .SP_W      (SP_W),
   .REF_MV    (REF_MV),
   .STEP_LOG2 (STEP_LOG2)
) chk_i (.*);

// File: tb/chg_vlim_clamp_tb_top.sv
`timescale 1ns/1ps
module chg_vlim_clamp_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] req_mv = '0;
   logic        req_wr = 1'b0;
   logic [3:0]  lim_therm = '0;
   logic [8:0]  vset_code;
   logic        vset_over;
   logic [2:0]  lim_idx;

   int n_chk = 0;
   int n_bad = 0;
   int model_req = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   chg_vlim_clamp dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_mv    (req_mv),
      .req_wr    (req_wr),
      .lim_therm (lim_therm),
      .vset_code (vset_code),
      .vset_over (vset_over),
      .lim_idx   (lim_idx)
   );

   function automatic int lvl_of(input int th);
      int n = 0;
      for (int i = 0; i < 4; i++) begin
         if (((th >> i) & 1) == 0) break;
         n++;
      end
      return n;
   endfunction

   function automatic int ceil_mv(input int lv);
      case (lv)
         0: return 4240;
         1: return 4304;
         2: return 4432;
         3: return 4512;
         default: return 5504;
      endcase
   endfunction

   function automatic int exp_code(input int r, input int lv);
      if (r < 1104) return 0;
      if (r > ceil_mv(lv)) return (ceil_mv(lv) - 1104) / 16;
      return (r - 1104) / 16;
   endfunction

   function automatic int exp_over(input int r, input int lv);
      return (r > ceil_mv(lv)) ? 1 : 0;
   endfunction

   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // Applies inputs at a falling edge, lets one rising edge pass, then compares.
   task automatic step(input string tag, input int r, input bit wr, input int th);
      int lv;
      @(negedge clk);
      req_mv    = 16'(r);
      req_wr    = wr;
      lim_therm = 4'(th);
      @(negedge clk);
      if (wr) model_req = r;
      lv = lvl_of(th);
      check({tag, " idx"},  32'(lim_idx),   lv);
      check({tag, " code"}, 32'(vset_code), exp_code(model_req, lv));
      check({tag, " over"}, 32'(vset_over), exp_over(model_req, lv));
      req_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
   end

   initial begin
      void'($urandom(32'd4101));
      req_mv    = 16'd5000;
      lim_therm = 4'hF;
      repeat (3) @(negedge clk);
      // R1: outputs zero under reset
      check("R1 code", 32'(vset_code), 0);
      check("R1 over", 32'(vset_over), 0);
      check("R1 idx",  32'(lim_idx),   0);
      rst_n = 1'b1;
      #1;
      check("R1 code after release", 32'(vset_code), 0);

      // R4 / R3: around the reference
      step("R4 below ref", 1103, 1, 4'hF);
      step("R4 zero req", 0, 1, 4'h0);
      step("R3 at ref", 1104, 1, 4'hF);
      step("R3 round down 1119", 1119, 1, 4'hF);
      step("R3 step 1120", 1120, 1, 4'hF);
      step("R3 mid", 3000, 1, 4'h1);

      // R2 / R5: each level at and just above its ceiling
      for (int lv = 0; lv < 5; lv++) begin
         int th = (1 << lv) - 1;
         step("R5 at ceiling", ceil_mv(lv), 1, th);
         step("R5 ceiling+1", ceil_mv(lv) + 1, 1, th);
      end
      step("R5 max request", 65535, 1, 4'h0);

      // R2: non-monotonic codes
      step("R2 therm 0101", 4300, 1, 4'h5);
      step("R2 therm 0010", 4300, 1, 4'h2);
      step("R2 therm 1011", 4400, 1, 4'hB);
      step("R2 therm 1000", 6000, 1, 4'h8);

      // R6: request change without strobe ignored
      step("R6 load", 2000, 1, 4'h3);
      step("R6 no write", 5000, 0, 4'h3);
      step("R6 no write low", 100, 0, 4'h3);

      // R7: limit change re-evaluates a held request
      step("R7 load high", 4500, 1, 4'h0);
      step("R7 raise limit", 4500, 0, 4'hF);
      step("R7 lower limit", 4500, 0, 4'h1);
      step("R7 mid limit", 4500, 0, 4'h7);

      // R8: in-range write clears the flag
      step("R8 set over", 6000, 1, 4'h3);
      step("R8 clear", 4000, 1, 4'h3);

      // R9 / mixed: random stimulus
      for (int k = 0; k < 400; k++) begin
         int r, th;
         bit wr;
         case ($urandom % 4)
            0: r = $urandom % 65536;
            1: r = 1090 + ($urandom % 40);
            default: r = 4200 + ($urandom % 1400);
         endcase
         th = $urandom % 16;
         wr = ($urandom % 3) != 0;
         step("R9 random", r, wr, th);
      end

      summary();
   end

endmodule